// File: doc/BRIEF.md
# Virtualized Reconfigurable Pipeline Datapath

This block runs an application made of up to sixteen virtual pipeline stages on a fabric that holds only a few physical stage slots, called stripes. Each stripe is a row of 8-bit ALU processing elements, one per data lane. Every virtual stage is stored as one configuration word in an on-chip configuration memory. The word gives an operation and an immediate for each processing element.

While an item is being computed, one stripe executes on each clock. In the same cycle, the next stripe in round-robin order is rewritten with the configuration of the following virtual stage. The last stripe feeds back into the first, so a sequence longer than the fabric is covered in several passes. Stage slots past the programmed stage count pass data through unchanged. A stage configuration therefore runs unchanged on any stripe count.

Software loads the configuration memory and the stage count through simple write strobes. Data enters and leaves on valid/ready streams. A result is offered for every accepted item once the required number of passes has completed.

Top module: `vpipe_fabric`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, the stage count is 1 and every configuration word is zero, which means ADD with immediate 0 in every lane.
- R2: Each processing element applies its 3-bit operation code to its lane byte `a` and its 8-bit immediate `k`. The codes are 0 add a+k, 1 subtract a-k, 2 AND, 3 OR, 4 XOR, 5 shift a left by one (immediate ignored), 6 pass a, and 7 the low byte of a*k. All arithmetic is modulo 256.
- R3: Virtual stages 0..N-1 are applied in that order. Each stage consumes the previous stage's result in the same lane, and lanes never mix.
- R4: With stage count N, out_valid rises exactly 4*ceil(N/4) cycles after the clock edge that accepts an item.
- R5: Configuration words of stages with index N or above have no effect on the result.
- R6: in_ready falls on the cycle after an accept and stays low until the result is handed off. While out_valid is 1, in_ready equals out_ready.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.
- R8: A stage-count write takes effect only when in_ready is 1 and out_valid is 0, and only for values 1..16. A write of any other value, or a write made at any other time, is ignored.
- R9: In configuration word bit layout, processing element i uses bits [11i+10:11i]: the operation code sits in [11i+10:11i+8] and the immediate in [11i+7:11i]. Data lane i is bits [8i+7:8i] of in_data and out_data.
- R10: When a result is handed off and a new item is waiting in the same cycle, the new item is accepted on that edge. Accepts then follow every 4*ceil(N/4)+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration memory write strobe |
| cfg_addr | input | 4 | Virtual stage index to write |
| cfg_data | input | 44 | Stage configuration word |
| cnt_we | input | 1 | Stage-count write strobe |
| cnt_val | input | 5 | New stage count |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Datapath can accept an item |
| in_data | input | 32 | Input item, four byte lanes |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result, four byte lanes |

## Verification
A result is due exactly 4*ceil(N/4) edges after the accepting edge, and in_ready follows on the edge after an accept or a handoff. The bench keeps a cycle-level reference that advances on each rising edge from the same inputs. It compares in_ready, out_valid and out_data against this reference on every falling edge, so any result that is one cycle early or late is caught.

Directed tests count falling edges from the accept to the first visible out_valid to measure latency. They also record the cycle number of each accept to measure streaming cadence. Expected bytes for single-stage operations are fixed by hand.

// File: rtl/vpipe_pkg.sv
package vpipe_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_SHL  = 3'd5,
      OP_PASS = 3'd6,
      OP_MUL  = 3'd7
   } pe_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_RUN,
      SQ_DONE
   } seq_st_e;
endpackage

// File: rtl/vpipe_pe.sv
module vpipe_pe
   import vpipe_pkg::*;
#(
   parameter int W = 8,
   localparam int F_W = OP_W + W
) (
   input  logic [F_W-1:0] cfg,
   input  logic [W-1:0]   a,
   output logic [W-1:0]   y
);
   pe_op_e      op;
   logic [W-1:0] imm;

   assign op  = pe_op_e'(cfg[F_W-1:W]);
   assign imm = cfg[W-1:0];

   always_comb begin
      case (op)
         OP_ADD:  y = a + imm;
         OP_SUB:  y = a - imm;
         OP_AND:  y = a & imm;
         OP_OR:   y = a | imm;
         OP_XOR:  y = a ^ imm;
         OP_SHL:  y = {a[W-2:0], 1'b0};
         OP_PASS: y = a;
         OP_MUL:  y = a * imm;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/vpipe_stripe.sv
module vpipe_stripe
   import vpipe_pkg::*;
#(
   parameter int W   = 8,
   parameter int NPE = 4,
   localparam int F_W   = OP_W + W,
   localparam int CFG_W = NPE * F_W,
   localparam int DAT_W = NPE * W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [CFG_W-1:0] ld_cfg,
   input  logic             ex_en,
   input  logic [DAT_W-1:0] din,
   output logic [DAT_W-1:0] q
);
   logic [CFG_W-1:0] cfg_q;
   logic [DAT_W-1:0] res;

   for (genvar i = 0; i < NPE; i++) begin : g_pe
      vpipe_pe #(.W(W)) u_pe (
         .cfg (cfg_q[i*F_W +: F_W]),
         .a   (din[i*W +: W]),
         .y   (res[i*W +: W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         q     <= '0;
      end else begin
         if (ld_en) cfg_q <= ld_cfg;
         if (ex_en) q     <= res;
      end
   end
endmodule

// File: rtl/vpipe_cfgmem.sv
module vpipe_cfgmem #(
   parameter int DEPTH = 16,
   parameter int CFG_W = 44,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [CFG_W-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [CFG_W-1:0] rdata
);
   logic [CFG_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/vpipe_seq.sv
module vpipe_seq
   import vpipe_pkg::*;
#(
   parameter int NSTRIPE    = 4,
   parameter int MAX_STAGES = 16,
   parameter int CNT_W      = 5,
   parameter int T_W        = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             out_ready,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_val,
   output logic             in_ready,
   output logic             out_valid,
   output logic             accept,
   output logic             running,
   output logic [T_W-1:0]   step,
   output logic [CNT_W-1:0] stage_n
);
   seq_st_e        st;
   logic [T_W-1:0] last_step;
   logic           cnt_ok;

   always_comb begin
      int passes;
      passes    = (int'(stage_n) + NSTRIPE - 1) / NSTRIPE;
      last_step = T_W'(passes * NSTRIPE - 1);
   end

   assign in_ready  = (st == SQ_IDLE) || ((st == SQ_DONE) && out_ready);
   assign out_valid = (st == SQ_DONE);
   assign running   = (st == SQ_RUN);
   assign accept    = in_valid && in_ready;
   assign cnt_ok    = cnt_we && (st == SQ_IDLE) && (cnt_val != '0)
                      && (int'(cnt_val) <= MAX_STAGES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         step    <= '0;
         stage_n <= CNT_W'(1);
      end else begin
         if (cnt_ok) stage_n <= cnt_val;
         if (accept) begin
            st   <= SQ_RUN;
            step <= '0;
         end else begin
            case (st)
               SQ_RUN:  if (step == last_step) st <= SQ_DONE;
                        else step <= step + 1'b1;
               SQ_DONE: if (out_ready) st <= SQ_IDLE;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/vpipe_fabric.sv
module vpipe_fabric
   import vpipe_pkg::*;
#(
   parameter int W          = 8,
   parameter int NPE        = 4,
   parameter int NSTRIPE    = 4,
   parameter int MAX_STAGES = 16,
   localparam int F_W   = OP_W + W,
   localparam int CFG_W = NPE * F_W,
   localparam int DAT_W = NPE * W,
   localparam int AW    = $clog2(MAX_STAGES),
   localparam int CNT_W = $clog2(MAX_STAGES + 1),
   localparam int T_W   = $clog2(MAX_STAGES + NSTRIPE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [AW-1:0]    cfg_addr,
   input  logic [CFG_W-1:0] cfg_data,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [DAT_W-1:0] in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [DAT_W-1:0] out_data
);
   localparam logic [F_W-1:0]   PASS_FLD = {OP_PASS, {W{1'b0}}};
   localparam logic [CFG_W-1:0] PASS_CFG = {NPE{PASS_FLD}};

   if (NSTRIPE < 2)          begin : g_chk_ns  $error("NSTRIPE must be at least 2");          end
   if (MAX_STAGES < NSTRIPE) begin : g_chk_ms  $error("MAX_STAGES must not be below NSTRIPE"); end
   if (W < 2)                begin : g_chk_w   $error("W must be at least 2");                 end

   logic             accept, running;
   logic [T_W-1:0]   step;
   logic [CNT_W-1:0] stage_n;
   logic [CFG_W-1:0] mem_rd, pf_cfg;
   logic [DAT_W-1:0] in_hold;
   logic [DAT_W-1:0] sq [NSTRIPE];
   int               pf_idx, pf_slot, ex_slot;

   vpipe_seq #(
      .NSTRIPE(NSTRIPE), .MAX_STAGES(MAX_STAGES), .CNT_W(CNT_W), .T_W(T_W)
   ) u_seq (
      .clk, .rst_n, .in_valid, .out_ready, .cnt_we, .cnt_val,
      .in_ready, .out_valid, .accept, .running, .step, .stage_n
   );

   always_comb begin
      pf_idx  = running ? int'(step) + 1 : 0;
      pf_slot = pf_idx % NSTRIPE;
      ex_slot = int'(step) % NSTRIPE;
      pf_cfg  = (pf_idx < int'(stage_n)) ? mem_rd : PASS_CFG;
   end

   vpipe_cfgmem #(.DEPTH(MAX_STAGES), .CFG_W(CFG_W)) u_mem (
      .clk, .rst_n,
      .we    (cfg_we),
      .waddr (cfg_addr),
      .wdata (cfg_data),
      .raddr (AW'(pf_idx)),
      .rdata (mem_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      in_hold <= '0;
      else if (accept) in_hold <= in_data;
   end

   for (genvar s = 0; s < NSTRIPE; s++) begin : g_stripe
      logic [DAT_W-1:0] din;
      if (s == 0) begin : g_head
         assign din = (step == '0) ? in_hold : sq[NSTRIPE-1];
      end else begin : g_body
         assign din = sq[s-1];
      end
      vpipe_stripe #(.W(W), .NPE(NPE)) u_stripe (
         .clk, .rst_n,
         .ld_en  ((accept || running) && (pf_slot == s)),
         .ld_cfg (pf_cfg),
         .ex_en  (running && (ex_slot == s)),
         .din    (din),
         .q      (sq[s])
      );
   end

   assign out_data = sq[NSTRIPE-1];
endmodule

// File: rtl/vpipe_fabric_chk.sv
module vpipe_fabric_chk #(
   parameter int NSTRIPE = 4,
   parameter int CNT_W   = 5,
   parameter int MAX_ST  = 16,
   parameter int DAT_W   = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [DAT_W-1:0] out_data,
   input logic [CNT_W-1:0] stage_n
);
   logic [7:0] since;
   int         due;

   always_comb due = ((int'(stage_n) + NSTRIPE - 1) / NSTRIPE) * NSTRIPE;

   always_ff @(posedge clk) begin
      if (!rst_n)                  since <= '0;
      else if (in_valid && in_ready) since <= '0;
      else if (since != 8'hFF)       since <= since + 1'b1;
   end

   // R4: result appears exactly on the pass boundary
   p_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (int'(since) == due));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (in_ready == out_ready));

   p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_n != '0) && (int'(stage_n) <= MAX_ST));
endmodule

bind vpipe_fabric vpipe_fabric_chk #(
   .NSTRIPE(NSTRIPE), .CNT_W(CNT_W), .MAX_ST(MAX_STAGES), .DAT_W(DAT_W)
) u_chk (
   .clk, .rst_n, .in_valid, .in_ready, .out_valid, .out_ready, .out_data, .stage_n
);

// File: tb/sim_vpipe_fabric.sv
`timescale 1ns/1ps
module sim_vpipe_fabric;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [43:0] cfg_data = '0;
   logic        cnt_we = 1'b0;
   logic [4:0]  cnt_val = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_data;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   vpipe_fabric u0 (.*);

   // ---------------- reference model ----------------
   logic [43:0] mmem [16];
   int          mst = 0, mcnt = 0, mN = 1, cyc = 0;
   logic [31:0] mres = '0, mout = '0;

   function automatic int steps_of(input int n);
      return ((n + 3) / 4) * 4;
   endfunction

   function automatic logic [31:0] ref_run(input logic [31:0] d, input int n);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) begin
         logic [7:0] v;
         v = d[8*i +: 8];
         for (int k = 0; k < n; k++) begin
            logic [10:0] f;
            logic [7:0]  k8;
            logic [15:0] p;
            f  = mmem[k][11*i +: 11];
            k8 = f[7:0];
            case (f[10:8])
               3'd0: v = v + k8;
               3'd1: v = v - k8;
               3'd2: v = v & k8;
               3'd3: v = v | k8;
               3'd4: v = v ^ k8;
               3'd5: v = {v[6:0], 1'b0};
               3'd6: v = v;
               default: begin p = v * k8; v = p[7:0]; end
            endcase
         end
         r[8*i +: 8] = v;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mst = 0; mcnt = 0; mN = 1; mout = '0; mres = '0;
         for (int i = 0; i < 16; i++) mmem[i] = '0;
      end else begin
         int  old;
         bit  rdy;
         cyc = cyc + 1;
         old = mst;
         rdy = (old == 0) || (old == 2 && out_ready);
         if (cfg_we) mmem[cfg_addr] = cfg_data;
         if (cnt_we && old == 0 && cnt_val >= 1 && cnt_val <= 16) mN = int'(cnt_val);
         if (old == 1) begin
            mcnt = mcnt - 1;
            if (mcnt == 0) begin mst = 2; mout = mres; end
         end else if (old == 2 && out_ready) mst = 0;
         if (in_valid && rdy) begin
            mst = 1; mcnt = steps_of(mN); mres = ref_run(in_data, mN);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #1;
         chk(in_ready == ((mst == 0) || (mst == 2 && out_ready)), "R6 in_ready",
             32'(in_ready), 32'((mst == 0) || (mst == 2 && out_ready)));
         chk(out_valid == (mst == 2), "R4 out_valid", 32'(out_valid), 32'(mst == 2));
         if (mst == 2) chk(out_data == mout, "R3 out_data", out_data, mout);
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [10:0] fld(input logic [2:0] op, input logic [7:0] k);
      return {op, k};
   endfunction

   task automatic wr_cfg(input int a, input logic [43:0] d);
      @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_data = d;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic wr_cnt(input int v);
      @(negedge clk); cnt_we = 1; cnt_val = 5'(v);
      @(negedge clk); cnt_we = 0;
   endtask

   task automatic send(input logic [31:0] d, output int acc_cyc);
      bit r;
      @(negedge clk); in_valid = 1; in_data = d;
      forever begin
         #1; r = in_ready;
         @(negedge clk);
         if (r) break;
      end
      acc_cyc = cyc;
      in_valid = 0;
   endtask

   task automatic wait_res(output int lat, output logic [31:0] d);
      lat = 0;
      forever begin
         #1;
         if (out_valid) break;
         @(negedge clk); lat++;
      end
      d = out_data;
      @(negedge clk);
   endtask

   task automatic run_one(input logic [31:0] din, input int exp_lat, input logic [31:0] exp_d,
                          input string req);
      int a, lat;
      logic [31:0] d;
      send(din, a);
      wait_res(lat, d);
      chk(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
      chk(d == exp_d, {req, " data"}, d, exp_d);
   endtask

   // ---------------- test sequence ----------------
   initial begin
      int a0, a1, a2, lat;
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
      chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
      // R1: default count 1 and zero configs give identity with one pass
      run_one(32'h11223344, 4, 32'h11223344, "R1");

      // R2: single-stage operations, hand computed
      wr_cfg(0, {fld(3'd3, 8'h80), fld(3'd2, 8'h0F), fld(3'd1, 8'h03), fld(3'd0, 8'h05)});
      run_one(32'h12345678, 4, 32'h9204537D, "R2 add/sub/and/or");
      wr_cfg(0, {fld(3'd7, 8'h03), fld(3'd6, 8'hAA), fld(3'd5, 8'h55), fld(3'd4, 8'hFF)});
      run_one(32'h12345678, 4, 32'h3634AC87, "R2 xor/shl/pass/mul");

      // R9: only lane 2 touched
      wr_cfg(0, {fld(3'd6, 8'h00), fld(3'd4, 8'hFF), fld(3'd6, 8'h00), fld(3'd6, 8'h00)});
      run_one(32'h00000000, 4, 32'h00FF0000, "R9 lane field position");

      // R5: two stages used, later stages would alter data
      wr_cfg(0, {4{fld(3'd0, 8'h01)}});
      wr_cfg(1, {4{fld(3'd0, 8'h01)}});
      wr_cfg(2, {4{fld(3'd4, 8'hFF)}});
      wr_cnt(2);
      run_one(32'h00000000, 4, 32'h02020202, "R5 stages above N");

      // R8: illegal values ignored
      wr_cnt(0);
      wr_cnt(17);
      run_one(32'h10203040, 4, 32'h12223242, "R8 illegal count ignored");
      // R8: write while busy ignored
      send(32'h01010101, a0);
      @(negedge clk); cnt_we = 1; cnt_val = 5'd16;
      @(negedge clk); cnt_we = 0;
      wait_res(lat, d);
      run_one(32'h01010101, 4, 32'h03030303, "R8 busy count write ignored");

      // R3 / R4: long sequences with feedback over several passes
      for (int k = 0; k < 16; k++)
         wr_cfg(k, {fld(3'(k % 8), 8'(k * 7 + 1)), fld(3'd0, 8'(k + 1)),
                    fld(3'((k + 3) % 8), 8'(k * 13 + 5)), fld(3'd5, 8'h00)});
      wr_cnt(16);
      run_one(32'hA5C3_0F01, 16, ref_run(32'hA5C3_0F01, 16), "R3 sixteen stages");
      wr_cnt(5);
      run_one(32'h5A3C_F010, 8, ref_run(32'h5A3C_F010, 5), "R4 five stages");
      wr_cnt(4);
      run_one(32'h0102_0304, 4, ref_run(32'h0102_0304, 4), "R4 four stages");
      wr_cnt(9);
      run_one(32'hFFEE_DDCC, 12, ref_run(32'hFFEE_DDCC, 9), "R4 nine stages");

      // R7 / R6: consumer stall
      wr_cnt(3);
      out_ready = 0;
      send(32'h7788_99AA, a0);
      repeat (10) @(negedge clk);
      #1;
      chk(out_valid == 1'b1, "R7 valid held", 32'(out_valid), 32'd1);
      chk(out_data == ref_run(32'h7788_99AA, 3), "R7 data held", out_data, ref_run(32'h7788_99AA, 3));
      chk(in_ready == 1'b0, "R6 ready low while stalled", 32'(in_ready), 32'd0);
      @(negedge clk); out_ready = 1;
      @(negedge clk);

      // R10: back-to-back stream, N=6 gives 8 steps
      wr_cnt(6);
      send(32'h0000_0001, a0);
      send(32'h0000_0002, a1);
      send(32'h0000_0003, a2);
      chk(a1 - a0 == 9, "R10 cadence 1-2", 32'(a1 - a0), 32'd9);
      chk(a2 - a1 == 9, "R10 cadence 2-3", 32'(a2 - a1), 32'd9);
      wait_res(lat, d);
      chk(d == ref_run(32'h0000_0003, 6), "R10 last data", d, ref_run(32'h0000_0003, 6));

      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule